// File: doc/BRIEF.md
# Buffered SPI Master

This block is a register-mapped serial peripheral interface master. Software reaches it through a simple 32-bit register port with one-cycle write and read strobes. Words written to the transmit data offset wait in a 16-entry transmit queue. A shift engine takes them one at a time and clocks them out on the serial data line. The engine clocks in one word from the serial input for every word it sends, and that word goes into a 16-entry receive queue. Software drains the receive queue through the receive data offset.

A hold bit in the control register stops the engine from taking words from the transmit queue. Software can therefore preload a burst and release it all at once. Once released, the engine keeps shifting until the queue is empty. Device selects are driven directly from an active-low select register, so software frames each transaction itself. Clock polarity, clock phase and bit order are set in the control register. An internal loopback connects the serial output to the serial input. The word width and the serial clock rate are fixed by parameters.

Top module: `spi_fifo_master`

## Requirements
- R1: The control register at offset 0x60 holds ten bits: bit 0 loopback, bit 1 enable, bit 2 master, bit 3 CPOL, bit 4 CPHA, bit 5 transmit queue clear, bit 6 receive queue clear, bit 7 manual select, bit 8 transmit hold, bit 9 LSB first. It resets to 0x100. Write bits above 9 are ignored, and a read-back returns the written value, including the loopback bit.
- R2: A read at offset 0x64 returns the status. Bit 0 is receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full and bit 4 mode fault, which always reads 0. All other bits read 0, so the value is 0x05 after reset.
- R3: A write to offset 0x68 pushes the low WIDTH bits into the 16-entry transmit queue. A push while the queue is full is dropped.
- R4: A read at offset 0x6C returns the oldest received word, zero-extended to 32 bits, and removes it. When the receive queue holds 16 words, a newly received word is discarded.
- R5: While the transmit hold bit is 1, no word leaves the transmit queue. After it is cleared, words are sent until the queue is empty.
- R6: Writing 1 to either queue-clear bit empties that queue. The bit reads back as 0 from the following cycle on.
- R7: In every CPOL/CPHA combination, a device that samples on the leading edge (CPHA=0) or the trailing edge (CPHA=1) receives the transmitted word exactly.
- R8: With LSB first set, bit 0 of the word is sent first and the first received bit lands in bit 0. Otherwise bit WIDTH-1 goes first.
- R9: While enable or master is 0, no word is started and the serial clock rests at the CPOL level.
- R10: With loopback set, the received word equals the sent word, whatever the external serial input does.
- R11: The select register at offset 0x70 resets to all ones. The select outputs follow it while manual select is 1 and are all ones otherwise.
- R12: Every word sent produces exactly one received word in the receive queue, whether or not software reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x6C) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SEL | Active-low device selects |

## Verification
The bench attaches a behavioural device that samples on the edge its phase setting dictates and answers with its own pattern. A mix-up of leading and trailing edges, a bit-order swap, or a one-bit slip in the shifter shows up as a corrupted capture or a corrupted received word. The bench overfills both queues. A design that wrapped its pointers would return the seventeenth word or lose the first. It holds words behind the hold bit and behind a cleared enable or master bit to catch an engine that starts early. It also checks that the clear bits empty their queue and read back as 0, which exposes a sticky clear bit that would keep the queue flushed.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h60;
  localparam logic [7:0] OFS_STAT = 8'h64;
  localparam logic [7:0] OFS_TXD  = 8'h68;
  localparam logic [7:0] OFS_RXD  = 8'h6C;
  localparam logic [7:0] OFS_SEL  = 8'h70;

  // Packed MSB first: bit 9 down to bit 0.
  typedef struct packed {
    logic lsb_first;
    logic tx_hold;
    logic sel_manual;
    logic rx_clr;
    logic tx_clr;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
    logic loop;
  } ctrl_t;

  localparam logic [9:0] CTRL_RST = 10'h100;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_MAX = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         do_push, do_pop;

  assign empty   = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (flush) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q[AW-1:0]] <= din;
  end

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q - rp_q) <= LVL_MAX);
  a_r3_full_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);
  a_r2_not_empty_and_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
  parameter int W    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         hold,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb,
  input  logic         loop,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_word,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_word,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso,
  output logic         busy
);
  localparam int EW = $clog2(2*W);
  localparam int DW = $clog2(HALF+1);
  localparam logic [EW-1:0] LAST = EW'(2*W-1);
  localparam logic [DW-1:0] DLIM = DW'(HALF-1);

  logic          busy_q, busy_d, sclk_q, sclk_d, push_q, push_d;
  logic [DW-1:0] div_q, div_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic          start, tick, sample_now, shift_now, rx_in;

  assign mosi    = lsb ? tx_q[0] : tx_q[W-1];
  assign rx_in   = loop ? mosi : miso;
  assign start   = !busy_q && run && !hold && !tx_empty;
  assign tick    = busy_q && (div_q == DLIM);
  assign sample_now = tick && (edge_q[0] == cpha);
  assign shift_now  = tick && (edge_q[0] != cpha) && (edge_q != '0) && (edge_q != LAST);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    div_d  = div_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    push_d = 1'b0;
    if (!busy_q) begin
      sclk_d = cpol;
      if (start) begin
        busy_d = 1'b1;
        tx_d   = tx_word;
        rx_d   = '0;
        div_d  = '0;
        edge_d = '0;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        sclk_d = ~sclk_q;
        edge_d = edge_q + 1'b1;
        if (edge_q == LAST) begin
          busy_d = 1'b0;
          push_d = 1'b1;
        end
      end
      if (sample_now) rx_d = lsb ? {rx_in, rx_q[W-1:1]} : {rx_q[W-2:0], rx_in};
      if (shift_now)  tx_d = lsb ? (tx_q >> 1) : (tx_q << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      push_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      push_q <= push_d;
      div_q  <= div_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign tx_pop  = start;
  assign rx_push = push_q;
  assign rx_word = rx_q;
  assign sclk    = sclk_q;
  assign busy    = busy_q;

  a_r5_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && hold) |=> !busy_q);
  a_r9_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q)) |-> (sclk_q == $past(cpol)));
  a_r12_push_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> (!busy_q && $past(busy_q)));
  a_r7_edge_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (edge_q == '0));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fm_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DEPTH      = 16,
  parameter int SCLK_HALF  = 2,
  parameter int NUM_SEL    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] ss_n
);
  ctrl_t              ctrl_q, ctrl_d;
  logic [NUM_SEL-1:0] sel_q, sel_d;
  logic               tx_push, tx_pop, tx_empty, tx_full;
  logic               rx_push, rx_pop, rx_empty, rx_full;
  logic [WIDTH-1:0]   tx_head, rx_head, rx_word;
  logic               eng_busy;

  assign tx_push = bus_wr && (bus_addr == OFS_TXD);
  assign rx_pop  = bus_rd && (bus_addr == OFS_RXD);

  always_comb begin
    ctrl_d        = ctrl_q;
    ctrl_d.tx_clr = 1'b0;
    ctrl_d.rx_clr = 1'b0;
    sel_d         = sel_q;
    if (bus_wr && bus_addr == OFS_CTRL) ctrl_d = ctrl_t'(bus_wdata[9:0]);
    if (bus_wr && bus_addr == OFS_SEL)  sel_d  = bus_wdata[NUM_SEL-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      sel_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = {22'b0, ctrl_q};
      OFS_STAT: bus_rdata = {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      OFS_RXD:  bus_rdata = 32'(rx_head);
      OFS_SEL:  bus_rdata = 32'(sel_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign ss_n = ctrl_q.sel_manual ? sel_q : '1;

  spi_fm_fifo #(.W(WIDTH), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_q.tx_clr),
    .push(tx_push), .din(bus_wdata[WIDTH-1:0]),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full));

  spi_fm_fifo #(.W(WIDTH), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(ctrl_q.rx_clr),
    .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  spi_fm_shifter #(.W(WIDTH), .HALF(SCLK_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q.enable && ctrl_q.master), .hold(ctrl_q.tx_hold),
    .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .lsb(ctrl_q.lsb_first), .loop(ctrl_q.loop),
    .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .miso(miso), .busy(eng_busy));

  a_r6_clear_self_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.tx_clr && !(bus_wr && bus_addr == OFS_CTRL)) |=> !ctrl_q.tx_clr);
  a_r9_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !(ctrl_q.enable && ctrl_q.master)) |=> !eng_busy);

endmodule

// File: tb/spi_fifo_master_tb_top.sv
module spi_fifo_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic        clk, rst_n, bus_wr, bus_rd, miso;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk, mosi;
  logic [3:0]  ss_n;

  int n_chk = 0;
  int n_bad = 0;

  spi_fifo_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural device on select 0
  logic         sl_cpol, sl_cpha, sl_lsb;
  logic [W-1:0] sl_pat, sl_cap;
  int           sl_n;

  always @(sclk) begin
    if (rst_n && ss_n[0] == 1'b0) begin
      if ((sclk != sl_cpol) == !sl_cpha) begin
        if (sl_n < W) begin
          if (sl_lsb) sl_cap[sl_n] = mosi;
          else        sl_cap[W-1-sl_n] = mosi;
        end
        sl_n = sl_n + 1;
      end else if (sl_n < W) begin
        miso = sl_lsb ? sl_pat[sl_n] : sl_pat[W-1-sl_n];
      end
    end
  end

  // {cpol, cpha, lsb, tx word, device pattern}
  localparam logic [18:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'h96, 8'hC1},
    {1'b1, 1'b0, 1'b0, 8'h0F, 8'h81},
    {1'b1, 1'b1, 1'b0, 8'hE2, 8'h5B},
    {1'b0, 1'b0, 1'b1, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b1, 8'h6D, 8'h29}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; miso = 0;
    sl_cpol = 0; sl_cpha = 0; sl_lsb = 0; sl_pat = 0; sl_cap = 0; sl_n = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(2);

    // Reset state
    rd(8'h60, v); chk("R1 reset ctrl", v, 32'h100);
    rd(8'h64, v); chk("R2 reset status", v, 32'h05);
    chk("R11 reset selects", {28'b0, ss_n}, 32'hF);
    chk("R9 reset sclk", {31'b0, sclk}, 32'h0);

    // R11 select register gated by manual bit
    wr(8'h70, 32'hE);
    chk("R11 manual off", {28'b0, ss_n}, 32'hF);
    wr(8'h60, 32'h180);
    chk("R11 manual on", {28'b0, ss_n}, 32'hE);
    wr(8'h70, 32'hF);
    chk("R11 deselect", {28'b0, ss_n}, 32'hF);

    // R1 control read-back, upper bits ignored
    wr(8'h60, 32'hFFFF_FC00 | 32'h39D);
    rd(8'h60, v); chk("R1 ctrl readback", v, 32'h39D);

    // R5 hold, then release
    wr(8'h60, 32'h187);
    wr(8'h68, 32'h42);
    idle(100);
    rd(8'h64, v); chk("R5 held word stays", v, 32'h01);
    wr(8'h60, 32'h087);
    idle(50);
    rd(8'h64, v); chk("R5 drained", v, 32'h04);
    rd(8'h6C, v); chk("R5 word looped", v, 32'h42);

    // R10 loopback ignores external input
    miso = 1'b1;
    wr(8'h68, 32'hFFFF_FFA5);
    idle(50);
    rd(8'h6C, v); chk("R10 loopback word", v, 32'hA5);
    miso = 1'b0;

    // R3 / R4 overfill both queues
    wr(8'h60, 32'h187);
    for (int i = 0; i < 17; i++) wr(8'h68, 32'h10 + i);
    rd(8'h64, v); chk("R3 tx full", v, 32'h09);
    wr(8'h60, 32'h087);
    idle(17 * 45);
    rd(8'h64, v); chk("R2 rx full", v, 32'h06);
    wr(8'h68, 32'h77);
    idle(60);
    rd(8'h64, v); chk("R4 rx still full", v, 32'h06);
    for (int i = 0; i < 16; i++) begin
      rd(8'h6C, v); chk("R4 rx order", v, 32'h10 + i);
    end
    rd(8'h64, v); chk("R4 newest discarded", v, 32'h05);

    // R6 queue clears
    wr(8'h60, 32'h187);
    for (int i = 0; i < 3; i++) wr(8'h68, 32'h20 + i);
    rd(8'h64, v); chk("R6 tx loaded", v, 32'h01);
    wr(8'h60, 32'h1A7);
    rd(8'h60, v); chk("R6 tx clear bit self-clears", v, 32'h187);
    rd(8'h64, v); chk("R6 tx emptied", v, 32'h05);
    wr(8'h60, 32'h087);
    wr(8'h68, 32'h3C);
    idle(50);
    rd(8'h64, v); chk("R12 rx holds word", v, 32'h04);
    wr(8'h60, 32'h0C7);
    rd(8'h60, v); chk("R6 rx clear bit self-clears", v, 32'h087);
    rd(8'h64, v); chk("R6 rx emptied", v, 32'h05);

    // R9 enable off, then master off
    wr(8'h60, 32'h08D);
    wr(8'h68, 32'h5A);
    idle(100);
    rd(8'h64, v); chk("R9 enable off no start", v, 32'h01);
    chk("R9 sclk at cpol", {31'b0, sclk}, 32'h1);
    wr(8'h60, 32'h08F);
    idle(50);
    rd(8'h6C, v); chk("R9 sent after enable", v, 32'h5A);
    wr(8'h60, 32'h08B);
    wr(8'h68, 32'h33);
    idle(100);
    rd(8'h64, v); chk("R9 master off no start", v, 32'h01);
    wr(8'h60, 32'h08F);
    idle(50);
    rd(8'h6C, v); chk("R9 sent after master", v, 32'h33);

    // R7 / R8 / R12 mode vectors against the device model
    for (int i = 0; i < 6; i++) begin
      logic [18:0] e;
      logic [31:0] cv;
      e = VEC[i];
      sl_cpol = e[18]; sl_cpha = e[17]; sl_lsb = e[16]; sl_pat = e[7:0];
      cv = 32'h186 | (32'(e[18]) << 3) | (32'(e[17]) << 4) | (32'(e[16]) << 9);
      wr(8'h60, cv);
      wr(8'h70, 32'hE);
      sl_n = 0; sl_cap = '0;
      miso = e[16] ? e[0] : e[7];
      wr(8'h68, {24'b0, e[15:8]});
      wr(8'h60, cv & ~32'h100);
      idle(60);
      wr(8'h70, 32'hF);
      chk("R7 R8 device capture", {24'b0, sl_cap}, {24'b0, e[15:8]});
      rd(8'h6C, v); chk("R12 R8 received word", v, {24'b0, e[7:0]});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule